// File: doc/BRIEF.md
# Shared Interrupt Distributor with Wide CPU Targets

This block sits between the interrupt sources of a multi-core system and the CPU interfaces. Software programs it over a 32-bit register bus. Each interrupt has an enable bit, a pending bit, an active bit and a trigger type. Shared interrupts also carry a CPU target mask. For each CPU interface, the block presents the lowest-numbered interrupt that is enabled, pending, not active and aimed at that CPU. If no interrupt qualifies, it presents ID 1023.

IDs 0–15 are software interrupts and IDs 16–31 are private per-CPU inputs. The enable, pending and active bits of IDs 0–31 exist once per CPU interface. A 4-bit CPU number that comes with each bus access selects which copy is read or written. IDs 32 and up are shared by all CPUs. Each shared ID has a target field of up to 16 bits, and two fields are packed into each 32-bit word. `NUM_IRQ` ranges from 33 to 510 and `NUM_CPU` from 1 to 16.

A CPU interface acknowledges an interrupt with a strobe plus an ID. The acknowledge marks the interrupt active and removes the pending state of an edge interrupt. Software clears the active state through the bus.

Top module: `irq_distributor`

## Requirements
- R1: A read of byte address 0x004 returns N in bits [4:0], with (N+1)*32 the smallest multiple of 32 that is at least `NUM_IRQ`. With the default of 64 interrupts, N is 1.
- R2: Enable-set (0x100) and enable-clear (0x180) hold interrupt i at word i/32, bit i%32. A written 1 sets or clears the bit, and a written 0 leaves it unchanged. Either address reads back the current enables.
- R3: For IDs 0–31, the enable, pending and active bits are separate per CPU. `bus_cpu_i` selects the copy that is accessed, and private input line 16*c+j drives ID 16+j of CPU c only.
- R4: The target field of shared ID i sits at 0x800 + ((2*i) & ~3), in bits [15:0] when i is even and bits [31:16] when i is odd. Bit c of the field selects CPU c. Bits at or above `NUM_CPU` are dropped and read as 0. For IDs 0–31, both halves read as the one-hot mask of the reading CPU.
- R5: The trigger configuration at 0x400 holds interrupt i at word i/32, bit i%32, where 1 means rising edge and 0 means active-high level. IDs 0–15 always read 1 and ignore writes.
- R6: Writing (map << 8) | id to 0xF00, with the ID in bits [3:0] and the CPU map in bits [23:8], makes software interrupt id pending on every CPU whose map bit is set.
- R7: Bit 0 of 0x000 is the global forwarding enable and resets to 0. While it is 0, every `irq_pend_o` bit is 0 and every ID output is 1023.
- R8: A level interrupt's pending bit copies its input line one cycle later and ignores pending-set writes. An edge interrupt's pending bit is set by a rising input edge, by a software event, or by a 1 written to pending-set (0x200). It is cleared by a 1 written to pending-clear (0x280) or by an acknowledge. Both addresses read back the pending bits.
- R9: An acknowledge strobe from CPU c with ID k sets k's active bit: the private copy of CPU c for k < 32, or the shared bit otherwise. Active bits read at 0x300 and are cleared by writing 1 to 0x380. An active interrupt is not forwarded.
- R10: For each CPU, the ID output is the lowest-numbered interrupt that is enabled, pending, not active and, for shared IDs, targeted at that CPU. `irq_pend_o` is high when such an interrupt exists; otherwise it is low and the ID is 1023.
- R11: A bus write whose address bits [1:0] are not zero has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_cpu_i | input | 4 | CPU number of the current bus access |
| bus_we_i | input | 1 | Write strobe |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address and CPU number |
| spi_i | input | NUM_IRQ-32 | Shared interrupt lines for IDs 32 and up |
| ppi_i | input | 16*NUM_CPU | Private lines, 16 per CPU, for IDs 16–31 |
| ack_i | input | NUM_CPU | Acknowledge strobe per CPU |
| ack_id_i | input | 10*NUM_CPU | Acknowledged ID per CPU |
| irq_pend_o | output | NUM_CPU | A forwardable interrupt exists for this CPU |
| irq_id_o | output | 10*NUM_CPU | Selected ID per CPU, 1023 when none |

## Verification
Register reads are combinational, so the bench samples read data one time step after it sets the address, with no clock edge in between. A write, an acknowledge or a change on an input line takes effect at the next rising edge. The per-CPU outputs are combinational from the registered state, so every output check is made at the falling edge that follows that rising edge. Level deassertion and the edge latch are each observed exactly one edge after the line changes. This makes a missing or extra register stage visible.

// File: rtl/intd_pkg.sv
package intd_pkg;
  localparam int unsigned IdW = 10;
  localparam logic [IdW-1:0] NoIrqId = 10'd1023;

  localparam logic [11:0] CtrlAddr = 12'h000;
  localparam logic [11:0] TypeAddr = 12'h004;
  localparam logic [11:0] SgiAddr  = 12'hF00;

  // 128-byte register groups, selected by address bits [11:7]
  localparam logic [4:0] GrpEnSet  = 5'h02;
  localparam logic [4:0] GrpEnClr  = 5'h03;
  localparam logic [4:0] GrpPdSet  = 5'h04;
  localparam logic [4:0] GrpPdClr  = 5'h05;
  localparam logic [4:0] GrpActRd  = 5'h06;
  localparam logic [4:0] GrpActClr = 5'h07;
  localparam logic [4:0] GrpCfg    = 5'h08;
endpackage

// File: rtl/intd_pick.sv
module intd_pick
  import intd_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64
) (
  input  logic [NUM_IRQ-1:0] cand_i,
  output logic               valid_o,
  output logic [IdW-1:0]     id_o
);
  always_comb begin
    valid_o = 1'b0;
    id_o    = NoIrqId;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        valid_o = 1'b1;
        id_o    = IdW'(i);
      end
    end
  end
endmodule

// File: rtl/intd_bank.sv
module intd_bank (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] en_set_i,
  input  logic [31:0] en_clr_i,
  input  logic [31:0] pd_set_i,
  input  logic [31:0] pd_clr_i,
  input  logic [31:0] ac_clr_i,
  input  logic [31:0] ack_i,
  input  logic [15:0] sgi_i,
  input  logic [15:0] ppi_i,
  input  logic [15:0] ppi_edge_i,
  output logic [31:0] en_o,
  output logic [31:0] pend_o,
  output logic [31:0] act_o
);
  logic [31:0] en_q, en_d, pd_q, pd_d, ac_q, ac_d;
  logic [15:0] ppi_q;

  always_comb begin
    en_d = (en_q | en_set_i) & ~en_clr_i;
    ac_d = (ac_q & ~ac_clr_i) | ack_i;
    pd_d[15:0] = (pd_q[15:0] & ~(pd_clr_i[15:0] | ack_i[15:0])) | sgi_i | pd_set_i[15:0];
    for (int j = 0; j < 16; j++) begin
      if (ppi_edge_i[j]) begin
        pd_d[16+j] = (pd_q[16+j] & ~(pd_clr_i[16+j] | ack_i[16+j]))
                   | (ppi_i[j] & ~ppi_q[j]) | pd_set_i[16+j];
      end else begin
        pd_d[16+j] = ppi_i[j];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      pd_q  <= '0;
      ac_q  <= '0;
      ppi_q <= '0;
    end else begin
      en_q  <= en_d;
      pd_q  <= pd_d;
      ac_q  <= ac_d;
      ppi_q <= ppi_i;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pd_q;
  assign act_o  = ac_q;
endmodule

// File: rtl/intd_shared.sv
module intd_shared #(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned NUM_CPU = 4,
  localparam int unsigned NumShr = NUM_IRQ - 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NumShr-1:0]         en_set_i,
  input  logic [NumShr-1:0]         en_clr_i,
  input  logic [NumShr-1:0]         pd_set_i,
  input  logic [NumShr-1:0]         pd_clr_i,
  input  logic [NumShr-1:0]         ac_clr_i,
  input  logic [NumShr-1:0]         ack_i,
  input  logic [NumShr-1:0]         line_i,
  input  logic [NUM_IRQ-1:16]       cfg_we_i,
  input  logic [NUM_IRQ-1:16]       cfg_val_i,
  input  logic [NumShr-1:0]         tgt_we_i,
  input  logic [NUM_CPU-1:0]        tgt_lo_i,
  input  logic [NUM_CPU-1:0]        tgt_hi_i,
  output logic [NumShr-1:0]         en_o,
  output logic [NumShr-1:0]         pend_o,
  output logic [NumShr-1:0]         act_o,
  output logic [NUM_IRQ-1:16]       edge_o,
  output logic [NumShr*NUM_CPU-1:0] tgt_o
);
  logic [NumShr-1:0]  en_q, en_d, pd_q, pd_d, ac_q, ac_d, line_q;
  logic [NUM_IRQ-1:16] cfg_q, cfg_d;
  logic [NUM_CPU-1:0] tgt_q [NumShr];

  always_comb begin
    en_d  = (en_q | en_set_i) & ~en_clr_i;
    ac_d  = (ac_q & ~ac_clr_i) | ack_i;
    cfg_d = (cfg_q & ~cfg_we_i) | (cfg_val_i & cfg_we_i);
    for (int k = 0; k < int'(NumShr); k++) begin
      if (cfg_q[k+32]) begin
        pd_d[k] = (pd_q[k] & ~(pd_clr_i[k] | ack_i[k])) | (line_i[k] & ~line_q[k]) | pd_set_i[k];
      end else begin
        pd_d[k] = line_i[k];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pd_q   <= '0;
      ac_q   <= '0;
      line_q <= '0;
      cfg_q  <= '0;
    end else begin
      en_q   <= en_d;
      pd_q   <= pd_d;
      ac_q   <= ac_d;
      line_q <= line_i;
      cfg_q  <= cfg_d;
    end
  end

  for (genvar k = 0; k < NumShr; k++) begin : g_tgt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tgt_q[k] <= '0;
      end else if (tgt_we_i[k]) begin
        tgt_q[k] <= (((k + 32) % 2) == 1) ? tgt_hi_i : tgt_lo_i;
      end
    end
    assign tgt_o[k*NUM_CPU +: NUM_CPU] = tgt_q[k];
  end

  assign en_o   = en_q;
  assign pend_o = pd_q;
  assign act_o  = ac_q;
  assign edge_o = cfg_q;
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import intd_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned NUM_CPU = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [3:0]             bus_cpu_i,
  input  logic                   bus_we_i,
  input  logic [11:0]            bus_addr_i,
  input  logic [31:0]            bus_wdata_i,
  output logic [31:0]            bus_rdata_o,
  input  logic [NUM_IRQ-33:0]    spi_i,
  input  logic [16*NUM_CPU-1:0]  ppi_i,
  input  logic [NUM_CPU-1:0]     ack_i,
  input  logic [10*NUM_CPU-1:0]  ack_id_i,
  output logic [NUM_CPU-1:0]     irq_pend_o,
  output logic [10*NUM_CPU-1:0]  irq_id_o
);
  localparam int unsigned NumShr  = NUM_IRQ - 32;
  localparam int unsigned NumWord = (NUM_IRQ + 31) / 32;

  function automatic logic [NUM_IRQ-1:0] spread(input logic [31:0] d, input logic [4:0] w);
    logic [NUM_IRQ-1:0] r;
    for (int i = 0; i < int'(NUM_IRQ); i++) r[i] = ((i / 32) == int'(w)) ? d[i%32] : 1'b0;
    return r;
  endfunction

  function automatic logic [NUM_IRQ-1:16] spread_hi(input logic [31:0] d, input logic [4:0] w);
    logic [NUM_IRQ-1:16] r;
    for (int i = 16; i < int'(NUM_IRQ); i++) r[i] = ((i / 32) == int'(w)) ? d[i%32] : 1'b0;
    return r;
  endfunction

  // ---------------- bus decode ----------------
  logic       wr_ok, is_tgt, gen_q, gen_d;
  logic [4:0] grp, word;
  logic [7:0] tword;
  logic [NUM_IRQ-1:0]  en_set_m, en_clr_m, pd_set_m, pd_clr_m, ac_clr_m;
  logic [NUM_IRQ-1:16] cfg_we_m, cfg_val_m;
  logic [NumShr-1:0]   tgt_we;

  assign wr_ok  = bus_we_i && (bus_addr_i[1:0] == 2'b00);
  assign grp    = bus_addr_i[11:7];
  assign word   = bus_addr_i[6:2];
  assign tword  = bus_addr_i[9:2];
  assign is_tgt = bus_addr_i[11:10] == 2'b10;

  assign en_set_m  = (wr_ok && grp == GrpEnSet)  ? spread(bus_wdata_i, word) : '0;
  assign en_clr_m  = (wr_ok && grp == GrpEnClr)  ? spread(bus_wdata_i, word) : '0;
  assign pd_set_m  = (wr_ok && grp == GrpPdSet)  ? spread(bus_wdata_i, word) : '0;
  assign pd_clr_m  = (wr_ok && grp == GrpPdClr)  ? spread(bus_wdata_i, word) : '0;
  assign ac_clr_m  = (wr_ok && grp == GrpActClr) ? spread(bus_wdata_i, word) : '0;
  assign cfg_we_m  = (wr_ok && grp == GrpCfg) ? spread_hi(32'hFFFF_FFFF, word) : '0;
  assign cfg_val_m = spread_hi(bus_wdata_i, word);

  always_comb begin
    for (int k = 0; k < int'(NumShr); k++) begin
      tgt_we[k] = wr_ok && is_tgt && (tword == 8'((k + 32) / 2));
    end
  end

  assign gen_d = (wr_ok && bus_addr_i == CtrlAddr) ? bus_wdata_i[0] : gen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gen_q <= 1'b0;
    else         gen_q <= gen_d;
  end

  // ---------------- acknowledge decode ----------------
  logic [NUM_IRQ-1:0] ack_m [NUM_CPU];
  logic [NumShr-1:0]  ack_sh;

  always_comb begin
    ack_sh = '0;
    for (int c = 0; c < int'(NUM_CPU); c++) begin
      for (int i = 0; i < int'(NUM_IRQ); i++) begin
        ack_m[c][i] = ack_i[c] && (ack_id_i[c*IdW +: IdW] == IdW'(i));
      end
      ack_sh = ack_sh | ack_m[c][NUM_IRQ-1:32];
    end
  end

  // ---------------- shared state ----------------
  logic [NumShr-1:0]         sh_en, sh_pd, sh_ac;
  logic [NUM_IRQ-1:16]       sh_edge;
  logic [NumShr*NUM_CPU-1:0] sh_tgt;

  intd_shared #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_shared (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_set_i  (en_set_m[NUM_IRQ-1:32]),
    .en_clr_i  (en_clr_m[NUM_IRQ-1:32]),
    .pd_set_i  (pd_set_m[NUM_IRQ-1:32]),
    .pd_clr_i  (pd_clr_m[NUM_IRQ-1:32]),
    .ac_clr_i  (ac_clr_m[NUM_IRQ-1:32]),
    .ack_i     (ack_sh),
    .line_i    (spi_i),
    .cfg_we_i  (cfg_we_m),
    .cfg_val_i (cfg_val_m),
    .tgt_we_i  (tgt_we),
    .tgt_lo_i  (bus_wdata_i[NUM_CPU-1:0]),
    .tgt_hi_i  (bus_wdata_i[16 +: NUM_CPU]),
    .en_o      (sh_en),
    .pend_o    (sh_pd),
    .act_o     (sh_ac),
    .edge_o    (sh_edge),
    .tgt_o     (sh_tgt)
  );

  // ---------------- per-CPU banks and selection ----------------
  logic [31:0]        bk_en [NUM_CPU];
  logic [31:0]        bk_pd [NUM_CPU];
  logic [31:0]        bk_ac [NUM_CPU];
  logic [NUM_IRQ-1:0] cand  [NUM_CPU];
  logic               sgi_wr;

  assign sgi_wr = wr_ok && (bus_addr_i == SgiAddr);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic        mine;
    logic [15:0] sgi_m;
    logic [NumShr-1:0] aimed;

    assign mine  = bus_cpu_i == 4'(c);
    assign sgi_m = (sgi_wr && bus_wdata_i[8+c]) ? (16'd1 << bus_wdata_i[3:0]) : 16'd0;

    intd_bank u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_set_i   (mine ? en_set_m[31:0] : 32'd0),
      .en_clr_i   (mine ? en_clr_m[31:0] : 32'd0),
      .pd_set_i   (mine ? pd_set_m[31:0] : 32'd0),
      .pd_clr_i   (mine ? pd_clr_m[31:0] : 32'd0),
      .ac_clr_i   (mine ? ac_clr_m[31:0] : 32'd0),
      .ack_i      (ack_m[c][31:0]),
      .sgi_i      (sgi_m),
      .ppi_i      (ppi_i[16*c +: 16]),
      .ppi_edge_i (sh_edge[31:16]),
      .en_o       (bk_en[c]),
      .pend_o     (bk_pd[c]),
      .act_o      (bk_ac[c])
    );

    for (genvar k = 0; k < NumShr; k++) begin : g_aim
      assign aimed[k] = sh_tgt[k*NUM_CPU + c];
    end

    assign cand[c] = gen_q ? {sh_en & sh_pd & ~sh_ac & aimed, bk_en[c] & bk_pd[c] & ~bk_ac[c]}
                           : '0;

    intd_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
      .cand_i  (cand[c]),
      .valid_o (irq_pend_o[c]),
      .id_o    (irq_id_o[c*IdW +: IdW])
    );
  end

  // ---------------- read path ----------------
  logic [31:0]        sel_en, sel_pd, sel_ac, rd;
  logic [NUM_IRQ-1:0] src;
  logic [15:0]        own;

  assign own = 16'd1 << bus_cpu_i;

  always_comb begin
    sel_en = '0;
    sel_pd = '0;
    sel_ac = '0;
    for (int c = 0; c < int'(NUM_CPU); c++) begin
      if (bus_cpu_i == 4'(c)) begin
        sel_en = bk_en[c];
        sel_pd = bk_pd[c];
        sel_ac = bk_ac[c];
      end
    end
  end

  always_comb begin
    rd  = '0;
    src = '0;
    case (grp)
      GrpEnSet, GrpEnClr:   src = {sh_en, sel_en};
      GrpPdSet, GrpPdClr:   src = {sh_pd, sel_pd};
      GrpActRd, GrpActClr:  src = {sh_ac, sel_ac};
      GrpCfg:               src = {sh_edge, 16'hFFFF};
      default:              src = '0;
    endcase
    if (bus_addr_i == CtrlAddr) begin
      rd[0] = gen_q;
    end else if (bus_addr_i == TypeAddr) begin
      rd[4:0] = 5'(NumWord - 1);
    end else if (is_tgt) begin
      for (int i = 0; i < int'(NUM_IRQ); i++) begin
        if (int'(tword) == i / 2) begin
          if (i < 32) rd[16*(i%2) +: 16] = own;
          else        rd[16*(i%2) +: 16] = 16'(sh_tgt[(i-32)*NUM_CPU +: NUM_CPU]);
        end
      end
    end else if (grp >= GrpEnSet && grp <= GrpCfg) begin
      for (int w = 0; w < int'(NumWord); w++) begin
        if (int'(word) == w) begin
          for (int b = 0; b < 32; b++) begin
            if (w * 32 + b < int'(NUM_IRQ)) rd[b] = src[w*32 + b];
          end
        end
      end
    end
  end

  assign bus_rdata_o = rd;
endmodule

// File: rtl/intd_chk.sv
module intd_chk #(
  parameter int unsigned NUM_IRQ = 64,
  parameter int unsigned NUM_CPU = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  gen_i,
  input logic [NUM_CPU-1:0]    ack_i,
  input logic [10*NUM_CPU-1:0] ack_id_i,
  input logic [NUM_CPU-1:0]    pend_i,
  input logic [10*NUM_CPU-1:0] id_i
);
  assert_global_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen_i |-> pend_i == '0);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
    assert_idle_id_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pend_i[c] |-> id_i[c*10 +: 10] == 10'd1023);

    assert_id_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_i[c] |-> int'(id_i[c*10 +: 10]) < int'(NUM_IRQ));

    assert_ack_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[c] && int'(ack_id_i[c*10 +: 10]) < int'(NUM_IRQ))
      |=> !(pend_i[c] && id_i[c*10 +: 10] == $past(ack_id_i[c*10 +: 10])));
  end
endmodule

bind irq_distributor intd_chk #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .gen_i    (gen_q),
  .ack_i    (ack_i),
  .ack_id_i (ack_id_i),
  .pend_i   (irq_pend_o),
  .id_i     (irq_id_o)
);

// File: tb/irq_distributor_tb_top.sv
module irq_distributor_tb_top;
  localparam int NI = 64;
  localparam int NC = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic [3:0]       bus_cpu_i;
  logic             bus_we_i;
  logic [11:0]      bus_addr_i;
  logic [31:0]      bus_wdata_i;
  logic [31:0]      bus_rdata_o;
  logic [NI-33:0]   spi_i;
  logic [16*NC-1:0] ppi_i;
  logic [NC-1:0]    ack_i;
  logic [10*NC-1:0] ack_id_i;
  logic [NC-1:0]    irq_pend_o;
  logic [10*NC-1:0] irq_id_o;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk_i = ~clk_i;

  irq_distributor #(.NUM_IRQ(NI), .NUM_CPU(NC)) dut_i (.*);

  typedef struct packed {
    logic        wr;
    logic [3:0]  cpu;
    logic [11:0] addr;
    logic [31:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd0, 12'h004, 32'h0000_0001, 8'd1},   // R1 type word
    '{1'b0, 4'd0, 12'h000, 32'h0000_0000, 8'd7},   // R7 reset enable off
    '{1'b1, 4'd0, 12'h100, 32'h0000_0005, 8'd2},   // R2
    '{1'b0, 4'd0, 12'h100, 32'h0000_0005, 8'd2},   // R2
    '{1'b0, 4'd1, 12'h100, 32'h0000_0000, 8'd3},   // R3 other bank untouched
    '{1'b1, 4'd0, 12'h180, 32'h0000_0004, 8'd2},   // R2 clear, zeros keep
    '{1'b0, 4'd0, 12'h180, 32'h0000_0001, 8'd2},   // R2
    '{1'b1, 4'd0, 12'h104, 32'hFFFF_0000, 8'd2},   // R2 shared word
    '{1'b0, 4'd2, 12'h104, 32'hFFFF_0000, 8'd2},   // R2
    '{1'b1, 4'd0, 12'h404, 32'h0000_00FF, 8'd5},   // R5
    '{1'b0, 4'd3, 12'h404, 32'h0000_00FF, 8'd5},   // R5
    '{1'b1, 4'd0, 12'h400, 32'h0000_0000, 8'd5},   // R5 SGI types fixed
    '{1'b0, 4'd0, 12'h400, 32'h0000_FFFF, 8'd5},   // R5
    '{1'b1, 4'd0, 12'h850, 32'hFFF3_0002, 8'd4},   // R4 ids 40/41
    '{1'b0, 4'd1, 12'h850, 32'h0003_0002, 8'd4},   // R4 upper bits dropped
    '{1'b0, 4'd2, 12'h808, 32'h0004_0004, 8'd4},   // R4 private read own mask
    '{1'b1, 4'd0, 12'h101, 32'hFFFF_FFFF, 8'd11},  // R11 misaligned
    '{1'b0, 4'd0, 12'h100, 32'h0000_0001, 8'd11},  // R11
    '{1'b1, 4'd0, 12'hF00, 32'h0000_0603, 8'd6},   // R6 id3 to cpu1,cpu2
    '{1'b0, 4'd1, 12'h200, 32'h0000_0008, 8'd6},   // R6
    '{1'b0, 4'd0, 12'h200, 32'h0000_0000, 8'd6},   // R6
    '{1'b0, 4'd2, 12'h280, 32'h0000_0008, 8'd6},   // R6
    '{1'b1, 4'd0, 12'h204, 32'h0000_0001, 8'd8},   // R8 edge id32 set
    '{1'b0, 4'd0, 12'h204, 32'h0000_0001, 8'd8},   // R8
    '{1'b1, 4'd0, 12'h284, 32'h0000_0001, 8'd8},   // R8 clear
    '{1'b0, 4'd0, 12'h204, 32'h0000_0000, 8'd8},   // R8
    '{1'b1, 4'd0, 12'h204, 32'h0001_0000, 8'd8},   // R8 level id48 set ignored
    '{1'b0, 4'd0, 12'h204, 32'h0000_0000, 8'd8}    // R8
  };

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] cpu, input logic [11:0] a, input logic [31:0] d);
    bus_cpu_i = cpu; bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] cpu, input logic [11:0] a, input logic [31:0] exp, input string tag);
    bus_cpu_i = cpu; bus_addr_i = a; bus_we_i = 1'b0;
    #1;
    check(bus_rdata_o == exp, tag, bus_rdata_o, exp);
  endtask

  task automatic step();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic ack(input int cpu, input logic [9:0] id);
    ack_i[cpu] = 1'b1; ack_id_i[cpu*10 +: 10] = id;
    step();
    ack_i[cpu] = 1'b0;
  endtask

  task automatic out_chk(input int cpu, input logic v, input logic [9:0] id, input string tag);
    logic [31:0] a, e;
    a = {21'd0, irq_pend_o[cpu], irq_id_o[cpu*10 +: 10]};
    e = {21'd0, v, id};
    check(a == e, tag, a, e);
  endtask

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; bus_cpu_i = '0; bus_we_i = 1'b0; bus_addr_i = '0; bus_wdata_i = '0;
    spi_i = '0; ppi_i = '0; ack_i = '0; ack_id_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int c = 0; c < NC; c++) out_chk(c, 1'b0, 10'd1023, "R10 reset idle");

    for (int v = 0; v < NV; v++) begin
      if (VECS[v].wr) wr(VECS[v].cpu, VECS[v].addr, VECS[v].data);
      else rd_chk(VECS[v].cpu, VECS[v].addr, VECS[v].data, $sformatf("R%0d vec%0d", VECS[v].req, v));
    end

    // R7: enabled and pending but globally off
    wr(4'd1, 12'h100, 32'h0000_0008);
    out_chk(1, 1'b0, 10'd1023, "R7 gate off");
    wr(4'd0, 12'h000, 32'h1);
    out_chk(1, 1'b1, 10'd3, "R10 sgi forwarded");
    out_chk(2, 1'b0, 10'd1023, "R10 not enabled");

    // R9: acknowledge
    ack(1, 10'd3);
    out_chk(1, 1'b0, 10'd1023, "R9 active blocks");
    rd_chk(4'd1, 12'h300, 32'h8, "R9 active read");
    rd_chk(4'd1, 12'h200, 32'h0, "R8 ack clears edge");
    wr(4'd1, 12'h380, 32'h8);
    rd_chk(4'd1, 12'h300, 32'h0, "R9 active clear");

    // R8: shared edge id33 to cpu0
    wr(4'd0, 12'h840, 32'h0001_0000);
    wr(4'd0, 12'h104, 32'h0000_0002);
    spi_i[1] = 1'b1;
    step();
    out_chk(0, 1'b1, 10'd33, "R8 edge latch");
    spi_i[1] = 1'b0;
    step();
    out_chk(0, 1'b1, 10'd33, "R8 edge held");
    ack(0, 10'd33);
    out_chk(0, 1'b0, 10'd1023, "R9 shared ack");
    wr(4'd0, 12'h384, 32'h2);

    // R10: level id48 to cpu0 and cpu2
    wr(4'd0, 12'h860, 32'h0000_0005);
    spi_i[16] = 1'b1;
    step();
    out_chk(0, 1'b1, 10'd48, "R10 multi target cpu0");
    out_chk(2, 1'b1, 10'd48, "R10 multi target cpu2");
    out_chk(1, 1'b0, 10'd1023, "R10 untargeted");
    wr(4'd0, 12'hF00, 32'h0000_0100);
    out_chk(0, 1'b1, 10'd0, "R10 lowest id wins");
    spi_i[16] = 1'b0;
    step();
    out_chk(2, 1'b0, 10'd1023, "R8 level drop");
    out_chk(0, 1'b1, 10'd0, "R10 remaining");

    // R3: private line of cpu3
    wr(4'd3, 12'h100, 32'h0010_0000);
    ppi_i[3*16 + 4] = 1'b1;
    step();
    out_chk(3, 1'b1, 10'd20, "R3 private line");
    out_chk(1, 1'b0, 10'd1023, "R3 other cpu");

    // R7: turn forwarding off
    wr(4'd0, 12'h000, 32'h0);
    for (int c = 0; c < NC; c++) out_chk(c, 1'b0, 10'd1023, "R7 global off");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule